// File: doc/BRIEF.md
# DRAM Read Transaction Sequencer

This block turns read requests into the ordered command stream that a packetized DRAM needs. Each request names a bank, a row, a starting column and a number of column reads. A table inside the controller holds, for every bank, whether a row is open and which one. Each access is sorted into one of three cases. A page hit needs only column reads. A page miss needs a precharge, an activate and then the reads. A page empty needs an activate and then the reads.

Every core interval is a static configuration input, counted in clock cycles, and is enforced with down-counters. A precharge waits for both the minimum row-active time after the activate and the read-to-precharge time after the last read to that bank, whichever ends later. After the last read of a request, a policy input chooses between closing the bank and leaving its row open. The block does not capture data. It only raises a data-valid window that starts a fixed latency after each read command.

A configured interval value N means that the dependent command appears no sooner than max(N,1) cycles after the command that started the interval. The command outputs are registered. The first command of an accepted request appears two cycles after the acceptance cycle at the earliest.

Top module: `rd_txn_seq`

## Requirements
- R1: A request whose bank is open with the same row (page hit) produces only read commands (code 3), with no activate or precharge.
- R2: A request whose bank is open with a different row (page miss) produces a precharge (code 2) to that bank, then an activate (code 1) of the new row, then the reads.
- R3: A request to a closed bank (page empty) produces an activate and then the reads. All banks are closed after reset.
- R4: With cfg_close_page high at the last read, a precharge to that bank follows the last read, and the bank counts as closed for the next request. With it low, the row stays open.
- R5: A request with count N issues N reads (count 0 issues one), at columns starting at req_col and rising by one each read, modulo the column width. Any two reads are at least max(cfg_t_cc,1) cycles apart.
- R6: A read comes at least max(cfg_t_rcd,1) cycles after the most recent activate. An activate comes at least max(cfg_t_rp,1) cycles after the last precharge to the same bank.
- R7: A precharge to a bank comes at least max(cfg_t_ras,1) cycles after that bank's activate and at least max(cfg_t_rdp,1) cycles after that bank's last read, so the later of the two bounds applies.
- R8: For a read shown in cycle r, rdata_valid is high in cycles r+cfg_t_cac through r+cfg_t_cac+max(cfg_t_cc,1)-1.
- R9: req_ready is high only while no request is in progress. It is high again in the cycle that shows the request's final command. At most one command appears per cycle, encoded on cmd_op as NOP=0, ACT=1, PRE=2, RD=3. cmd_bank, cmd_row and cmd_col are zero when cmd_op is NOP. cmd_row is valid for ACT and cmd_col for RD; the unused field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_bank | input | 3 | Target bank |
| req_row | input | 12 | Target row |
| req_col | input | 7 | First column |
| req_count | input | 4 | Number of reads (0 means one) |
| cfg_t_rp | input | 4 | Precharge-to-activate cycles |
| cfg_t_rcd | input | 4 | Activate-to-read cycles |
| cfg_t_cc | input | 4 | Read-to-read cycles and data window length |
| cfg_t_cac | input | 4 | Read-to-data cycles |
| cfg_t_ras | input | 4 | Activate-to-precharge cycles |
| cfg_t_rdp | input | 4 | Read-to-precharge cycles |
| cfg_close_page | input | 1 | Close the bank after the last read |
| cmd_op | output | 2 | Command code |
| cmd_bank | output | 3 | Command bank |
| cmd_row | output | 12 | Row for ACT |
| cmd_col | output | 7 | Column for RD |
| rdata_valid | output | 1 | Read data window |

## Verification
The bench builds the block with its defaults: eight banks, 4-bit timing fields, a 12-bit row and a 7-bit column. The 4-bit fields allow intervals up to 15 cycles, so a 15-cycle read latency with a 7-cycle window can be tested, as well as a row-active bound long enough to delay a miss precharge past the read-to-precharge bound. The 7-bit column lets a three-read burst that starts at column 127 wrap to 0. An all-zero configuration exercises the one-cycle minimum on every interval. Toggling the page policy exercises both the close-then-reactivate path and the miss path.

// File: rtl/rts_pkg.sv
package rts_pkg;
    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_ACT = 2'd1,
        OP_PRE = 2'd2,
        OP_RD  = 2'd3
    } rts_op_e;

    typedef enum logic [1:0] {
        CL_HIT   = 2'd0,
        CL_MISS  = 2'd1,
        CL_EMPTY = 2'd2
    } rts_class_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_ACT   = 3'd2,
        ST_RD    = 3'd3,
        ST_CLOSE = 3'd4
    } rts_state_e;
endpackage

// File: rtl/rts_row_table.sv
module rts_row_table
    import rts_pkg::*;
#(
    parameter int NB    = 8,
    parameter int ROW_W = 12,
    localparam int BW   = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rts_op_e          upd_op,
    input  logic [BW-1:0]    upd_bank,
    input  logic [ROW_W-1:0] upd_row,
    input  logic [BW-1:0]    look_bank,
    input  logic [ROW_W-1:0] look_row,
    output rts_class_e       look_class
);
    logic [NB-1:0]    open_d, open_q;
    logic [ROW_W-1:0] row_d [NB];
    logic [ROW_W-1:0] row_q [NB];

    always_comb begin
        open_d = open_q;
        for (int b = 0; b < NB; b++) begin
            row_d[b] = row_q[b];
        end
        if (upd_op == OP_ACT) begin
            open_d[upd_bank] = 1'b1;
            row_d[upd_bank]  = upd_row;
        end else if (upd_op == OP_PRE) begin
            open_d[upd_bank] = 1'b0;
        end
        if (!open_q[look_bank]) begin
            look_class = CL_EMPTY;
        end else if (row_q[look_bank] == look_row) begin
            look_class = CL_HIT;
        end else begin
            look_class = CL_MISS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= '0;
            for (int b = 0; b < NB; b++) begin
                row_q[b] <= '0;
            end
        end else begin
            open_q <= open_d;
            for (int b = 0; b < NB; b++) begin
                row_q[b] <= row_d[b];
            end
        end
    end
endmodule

// File: rtl/rts_bank_timers.sv
module rts_bank_timers
    import rts_pkg::*;
#(
    parameter int NB = 8,
    parameter int TW = 4,
    localparam int BW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  rts_op_e       iss_op,
    input  logic [BW-1:0] iss_bank,
    input  logic [TW-1:0] cfg_t_rp,
    input  logic [TW-1:0] cfg_t_ras,
    input  logic [TW-1:0] cfg_t_rdp,
    output logic [NB-1:0] pre_ok,
    output logic [NB-1:0] act_ok
);
    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [TW-1:0] ras_d, ras_q, rdp_d, rdp_q, rp_d, rp_q;
        logic          hit;

        always_comb begin
            hit   = (iss_bank == BW'(b));
            ras_d = (ras_q != '0) ? ras_q - 1'b1 : '0;
            rdp_d = (rdp_q != '0) ? rdp_q - 1'b1 : '0;
            rp_d  = (rp_q  != '0) ? rp_q  - 1'b1 : '0;
            if (hit) begin
                case (iss_op)
                    OP_ACT:  ras_d = cfg_t_ras;
                    OP_RD:   rdp_d = cfg_t_rdp;
                    OP_PRE:  rp_d  = cfg_t_rp;
                    default: ;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ras_q <= '0;
                rdp_q <= '0;
                rp_q  <= '0;
            end else begin
                ras_q <= ras_d;
                rdp_q <= rdp_d;
                rp_q  <= rp_d;
            end
        end

        assign pre_ok[b] = (ras_q <= TW'(1)) && (rdp_q <= TW'(1));
        assign act_ok[b] = (rp_q <= TW'(1));
    end
endmodule

// File: rtl/rts_data_window.sv
module rts_data_window #(
    parameter int TW   = 4,
    localparam int WIN = 2 * (1 << TW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_issue,
    input  logic [TW-1:0] cfg_t_cac,
    input  logic [TW-1:0] cfg_t_cc,
    output logic          data_valid
);
    logic [WIN-1:0] win_d, win_q, mask;
    int unsigned    lo, hi;

    always_comb begin
        lo = int'(cfg_t_cac);
        hi = lo + ((cfg_t_cc == '0) ? 1 : int'(cfg_t_cc));
        for (int k = 0; k < WIN; k++) begin
            mask[k] = (k >= lo) && (k < hi);
        end
        win_d = win_q >> 1;
        if (rd_issue) begin
            win_d = win_d | mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign data_valid = win_q[0];
endmodule

// File: rtl/rd_txn_seq.sv
module rd_txn_seq
    import rts_pkg::*;
#(
    parameter int NB    = 8,
    parameter int ROW_W = 12,
    parameter int COL_W = 7,
    parameter int CNT_W = 4,
    parameter int TW    = 4,
    localparam int BW   = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [BW-1:0]    req_bank,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [CNT_W-1:0] req_count,
    input  logic [TW-1:0]    cfg_t_rp,
    input  logic [TW-1:0]    cfg_t_rcd,
    input  logic [TW-1:0]    cfg_t_cc,
    input  logic [TW-1:0]    cfg_t_cac,
    input  logic [TW-1:0]    cfg_t_ras,
    input  logic [TW-1:0]    cfg_t_rdp,
    input  logic             cfg_close_page,
    output logic [1:0]       cmd_op,
    output logic [BW-1:0]    cmd_bank,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col,
    output logic             rdata_valid
);
    typedef struct packed {
        rts_state_e       st;
        logic [BW-1:0]    bank;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [CNT_W-1:0] left;
        logic [TW-1:0]    rcd;
        logic [TW-1:0]    tcc;
        rts_op_e          op;
        logic [BW-1:0]    o_bank;
        logic [ROW_W-1:0] o_row;
        logic [COL_W-1:0] o_col;
    } seq_s;

    seq_s          s_d, s_q;
    rts_class_e    cls;
    logic [NB-1:0] pre_ok, act_ok;

    rts_row_table #(.NB(NB), .ROW_W(ROW_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_op    (s_d.op),
        .upd_bank  (s_d.o_bank),
        .upd_row   (s_d.o_row),
        .look_bank (req_bank),
        .look_row  (req_row),
        .look_class(cls)
    );

    rts_bank_timers #(.NB(NB), .TW(TW)) u_timers (
        .clk      (clk),
        .rst_n    (rst_n),
        .iss_op   (s_d.op),
        .iss_bank (s_d.o_bank),
        .cfg_t_rp (cfg_t_rp),
        .cfg_t_ras(cfg_t_ras),
        .cfg_t_rdp(cfg_t_rdp),
        .pre_ok   (pre_ok),
        .act_ok   (act_ok)
    );

    rts_data_window #(.TW(TW)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_issue  (s_d.op == OP_RD),
        .cfg_t_cac (cfg_t_cac),
        .cfg_t_cc  (cfg_t_cc),
        .data_valid(rdata_valid)
    );

    always_comb begin
        s_d        = s_q;
        s_d.op     = OP_NOP;
        s_d.o_bank = '0;
        s_d.o_row  = '0;
        s_d.o_col  = '0;
        s_d.rcd    = (s_q.rcd != '0) ? s_q.rcd - 1'b1 : '0;
        s_d.tcc    = (s_q.tcc != '0) ? s_q.tcc - 1'b1 : '0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.bank = req_bank;
                    s_d.row  = req_row;
                    s_d.col  = req_col;
                    s_d.left = (req_count == '0) ? CNT_W'(1) : req_count;
                    case (cls)
                        CL_HIT:  s_d.st = ST_RD;
                        CL_MISS: s_d.st = ST_PRE;
                        default: s_d.st = ST_ACT;
                    endcase
                end
            end
            ST_PRE: begin
                if (pre_ok[s_q.bank]) begin
                    s_d.op     = OP_PRE;
                    s_d.o_bank = s_q.bank;
                    s_d.st     = ST_ACT;
                end
            end
            ST_ACT: begin
                if (act_ok[s_q.bank]) begin
                    s_d.op     = OP_ACT;
                    s_d.o_bank = s_q.bank;
                    s_d.o_row  = s_q.row;
                    s_d.rcd    = cfg_t_rcd;
                    s_d.st     = ST_RD;
                end
            end
            ST_RD: begin
                if (s_q.rcd <= TW'(1) && s_q.tcc <= TW'(1)) begin
                    s_d.op     = OP_RD;
                    s_d.o_bank = s_q.bank;
                    s_d.o_col  = s_q.col;
                    s_d.tcc    = cfg_t_cc;
                    s_d.col    = s_q.col + 1'b1;
                    s_d.left   = s_q.left - 1'b1;
                    if (s_q.left == CNT_W'(1)) begin
                        s_d.st = cfg_close_page ? ST_CLOSE : ST_IDLE;
                    end
                end
            end
            ST_CLOSE: begin
                if (pre_ok[s_q.bank]) begin
                    s_d.op     = OP_PRE;
                    s_d.o_bank = s_q.bank;
                    s_d.st     = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
            s_q.op <= OP_NOP;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = (s_q.st == ST_IDLE);
    assign cmd_op    = s_q.op;
    assign cmd_bank  = s_q.o_bank;
    assign cmd_row   = s_q.o_row;
    assign cmd_col   = s_q.o_col;
endmodule

// File: rtl/rts_checker.sv
module rts_checker #(
    parameter int NB    = 8,
    parameter int ROW_W = 12,
    parameter int COL_W = 7,
    parameter int TW    = 4,
    localparam int BW   = $clog2(NB),
    localparam int GW   = TW + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       cmd_op,
    input logic [BW-1:0]    cmd_bank,
    input logic [ROW_W-1:0] cmd_row,
    input logic [COL_W-1:0] cmd_col,
    input logic             rdata_valid,
    input logic [TW-1:0]    cfg_t_rp,
    input logic [TW-1:0]    cfg_t_rcd,
    input logic [TW-1:0]    cfg_t_cc,
    input logic [TW-1:0]    cfg_t_ras,
    input logic [TW-1:0]    cfg_t_rdp
);
    localparam logic [GW-1:0] SAT = '1;

    logic [GW-1:0] act_gap [NB];
    logic [GW-1:0] pre_gap [NB];
    logic [GW-1:0] rd_gap  [NB];
    logic [GW-1:0] any_rd_gap, any_act_gap;
    logic [NB-1:0] open_q;
    logic          rd_seen_q;

    function automatic logic [GW-1:0] eff(input logic [TW-1:0] v);
        return (v == '0) ? GW'(1) : GW'(v);
    endfunction

    function automatic logic [GW-1:0] bump(input logic [GW-1:0] g);
        return (g == SAT) ? SAT : g + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) begin
                act_gap[b] <= SAT;
                pre_gap[b] <= SAT;
                rd_gap[b]  <= SAT;
            end
            any_rd_gap  <= SAT;
            any_act_gap <= SAT;
            open_q      <= '0;
            rd_seen_q   <= 1'b0;
        end else begin
            for (int b = 0; b < NB; b++) begin
                act_gap[b] <= (cmd_op == 2'd1 && cmd_bank == BW'(b)) ? GW'(1) : bump(act_gap[b]);
                pre_gap[b] <= (cmd_op == 2'd2 && cmd_bank == BW'(b)) ? GW'(1) : bump(pre_gap[b]);
                rd_gap[b]  <= (cmd_op == 2'd3 && cmd_bank == BW'(b)) ? GW'(1) : bump(rd_gap[b]);
            end
            any_rd_gap  <= (cmd_op == 2'd3) ? GW'(1) : bump(any_rd_gap);
            any_act_gap <= (cmd_op == 2'd1) ? GW'(1) : bump(any_act_gap);
            if (cmd_op == 2'd1) open_q[cmd_bank] <= 1'b1;
            if (cmd_op == 2'd2) open_q[cmd_bank] <= 1'b0;
            if (cmd_op == 2'd3) rd_seen_q <= 1'b1;
        end
    end

    p_rd_to_open_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op == 2'd3 |-> open_q[cmd_bank]);

    p_pre_to_open_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op == 2'd2 |-> open_q[cmd_bank]);

    p_act_to_closed_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op == 2'd1 |-> !open_q[cmd_bank]);

    p_rd_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op == 2'd3 |-> any_rd_gap >= eff(cfg_t_cc));

    p_rd_after_act_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op == 2'd3 |-> any_act_gap >= eff(cfg_t_rcd));

    p_act_after_pre_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op == 2'd1 |-> pre_gap[cmd_bank] >= eff(cfg_t_rp));

    p_pre_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op == 2'd2 |-> (act_gap[cmd_bank] >= eff(cfg_t_ras)) &&
                           (rd_gap[cmd_bank] >= eff(cfg_t_rdp)));

    p_valid_needs_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> rd_seen_q);

    p_ready_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    p_nop_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op == 2'd0 |-> cmd_bank == '0 && cmd_row == '0 && cmd_col == '0);
endmodule

bind rd_txn_seq rts_checker #(.NB(NB), .ROW_W(ROW_W), .COL_W(COL_W), .TW(TW)) u_rts_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .cmd_op     (cmd_op),
    .cmd_bank   (cmd_bank),
    .cmd_row    (cmd_row),
    .cmd_col    (cmd_col),
    .rdata_valid(rdata_valid),
    .cfg_t_rp   (cfg_t_rp),
    .cfg_t_rcd  (cfg_t_rcd),
    .cfg_t_cc   (cfg_t_cc),
    .cfg_t_ras  (cfg_t_ras),
    .cfg_t_rdp  (cfg_t_rdp)
);

// File: tb/test_rd_txn_seq.sv
`timescale 1ns/1ps
module test_rd_txn_seq;
    localparam int NB = 8, ROW_W = 12, COL_W = 7, CNT_W = 4, TW = 4, BW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [BW-1:0] req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [CNT_W-1:0] req_count = '0;
    logic [TW-1:0] t_rp, t_rcd, t_cc, t_cac, t_ras, t_rdp;
    logic close_page;
    logic [1:0] cmd_op;
    logic [BW-1:0] cmd_bank;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;
    logic rdata_valid;

    always #10 clk = ~clk;

    rd_txn_seq #(.NB(NB), .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W), .TW(TW)) i_rd_txn_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_count(req_count),
        .cfg_t_rp(t_rp), .cfg_t_rcd(t_rcd), .cfg_t_cc(t_cc), .cfg_t_cac(t_cac),
        .cfg_t_ras(t_ras), .cfg_t_rdp(t_rdp), .cfg_close_page(close_page),
        .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .rdata_valid(rdata_valid)
    );

    int nchecks = 0, nerr = 0, cyc = 0;
    bit done = 1'b0;

    // behavioural reference: planned command per cycle
    int exp_op [int];
    int exp_bank [int];
    int exp_row [int];
    int exp_col [int];
    bit exp_dv [int];
    int m_act [NB], m_pre [NB], m_rd [NB], m_row [NB];
    bit m_open [NB];
    int m_last_rd = -1000, m_last_act = -1000, m_busy = 0;

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic put(input int c, input int op, input int b, input int r, input int col);
        exp_op[c] = op; exp_bank[c] = b; exp_row[c] = r; exp_col[c] = col;
        m_busy = c;
    endtask

    task automatic plan(input int a);
        int b, r, c, n, t;
        b = int'(req_bank); r = int'(req_row); c = int'(req_col);
        n = (req_count == 0) ? 1 : int'(req_count);
        t = a + 2;
        if (!(m_open[b] && m_row[b] == r)) begin
            if (m_open[b]) begin
                t = mx(t, mx(m_act[b] + eff(t_ras), m_rd[b] + eff(t_rdp)));
                put(t, 2, b, 0, 0); m_pre[b] = t; m_open[b] = 0; t++;
            end
            t = mx(t, m_pre[b] + eff(t_rp));
            put(t, 1, b, r, 0); m_act[b] = t; m_last_act = t;
            m_open[b] = 1; m_row[b] = r; t++;
        end
        for (int i = 0; i < n; i++) begin
            t = mx(t, mx(m_last_act + eff(t_rcd), m_last_rd + eff(t_cc)));
            put(t, 3, b, 0, (c + i) % (1 << COL_W));
            m_rd[b] = t; m_last_rd = t;
            for (int k = 0; k < eff(t_cc); k++) exp_dv[t + int'(t_cac) + k] = 1'b1;
            t++;
        end
        if (close_page) begin
            t = mx(t, mx(m_act[b] + eff(t_ras), m_rd[b] + eff(t_rdp)));
            put(t, 2, b, 0, 0); m_pre[b] = t; m_open[b] = 0;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, expv);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int eo, eb, er, ec;
            string tg;
            eo = exp_op.exists(cyc) ? exp_op[cyc] : 0;
            eb = exp_op.exists(cyc) ? exp_bank[cyc] : 0;
            er = exp_op.exists(cyc) ? exp_row[cyc] : 0;
            ec = exp_op.exists(cyc) ? exp_col[cyc] : 0;
            case (eo)
                1: tg = "R3/R2/R6 act";
                2: tg = "R2/R4/R7 pre";
                3: tg = "R1/R5/R6 rd";
                default: tg = "R9 nop";
            endcase
            chk(int'(cmd_op) == eo, {tg, " op"}, int'(cmd_op), eo);
            chk(int'(cmd_bank) == eb, {tg, " bank"}, int'(cmd_bank), eb);
            chk(int'(cmd_row) == er, {tg, " row"}, int'(cmd_row), er);
            chk(int'(cmd_col) == ec, {tg, " col"}, int'(cmd_col), ec);
            chk(rdata_valid == exp_dv.exists(cyc), "R8 data window",
                int'(rdata_valid), int'(exp_dv.exists(cyc)));
            chk(req_ready == (cyc >= m_busy), "R9 ready", int'(req_ready), int'(cyc >= m_busy));
            if (req_valid && req_ready) plan(cyc);
        end
    end

    task automatic send(input int b, input int r, input int c, input int n);
        @(posedge clk); #1;
        req_bank = BW'(b); req_row = ROW_W'(r); req_col = COL_W'(c); req_count = CNT_W'(n);
        req_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic settle();
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        repeat (40) @(posedge clk);
    endtask

    task automatic set_cfg(input int rp, input int rcd, input int cc, input int cac,
                           input int ras, input int rdp, input bit cl);
        settle();
        #1;
        t_rp = TW'(rp); t_rcd = TW'(rcd); t_cc = TW'(cc); t_cac = TW'(cac);
        t_ras = TW'(ras); t_rdp = TW'(rdp); close_page = cl;
    endtask

    initial begin
        for (int b = 0; b < NB; b++) begin
            m_act[b] = -1000; m_pre[b] = -1000; m_rd[b] = -1000; m_row[b] = 0; m_open[b] = 0;
        end
        t_rp = 3; t_rcd = 4; t_cc = 2; t_cac = 5; t_ras = 9; t_rdp = 3; close_page = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        // reset state: idle, no command, no data (R9, R3)
        chk(req_ready == 1'b1, "R9 reset ready", int'(req_ready), 1);
        chk(cmd_op == 2'd0, "R9 reset op", int'(cmd_op), 0);
        chk(rdata_valid == 1'b0, "R8 reset valid", int'(rdata_valid), 0);
        // R3 empty bank, R5 two reads
        send(0, 5, 10, 2);
        // R1 hit on same row
        send(0, 5, 20, 3);
        // R2 miss, R7 precharge bound
        send(0, 7, 0, 1);
        // R5 count 0 means one read
        send(3, 9, 44, 0);
        send(3, 9, 45, 4);
        send(0, 7, 1, 2);
        send(6, 100, 2, 1);
        // R4 close policy: reopened bank sees empty and waits tRP (R6)
        set_cfg(6, 2, 3, 4, 8, 5, 1'b1);
        send(5, 11, 3, 2);
        send(5, 11, 9, 1);
        send(5, 12, 0, 3);
        // all-zero intervals: one-cycle minimum
        set_cfg(0, 0, 0, 0, 0, 0, 1'b0);
        send(1, 1, 1, 3);
        send(1, 2, 5, 2);
        send(1, 2, 7, 1);
        send(2, 3, 0, 5);
        // long intervals, R8 latest window, R7 tRAS later than tRDP
        set_cfg(10, 1, 7, 15, 15, 2, 1'b0);
        send(4, 50, 8, 2);
        send(4, 51, 9, 1);
        set_cfg(2, 3, 1, 2, 3, 12, 1'b0);
        send(4, 51, 10, 2);
        send(4, 52, 0, 1);
        // R5 column wrap
        send(7, 8, 127, 3);
        set_cfg(1, 2, 4, 1, 5, 6, 1'b1);
        send(7, 8, 126, 15);
        send(2, 3, 4, 2);
        settle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchecks++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end
endmodule